// File: doc/BRIEF.md
# Wide-Mode Vertical Scan and Polarity Controller

This block sits between the line and field timing of a video path and the vertical drive of a 4:3 delta-pixel panel. It decides, once per video line, what the panel's vertical scanner does on that line: advance by one row, advance by four rows at quadruple speed, or hold. It also produces the AC drive polarity level for the panel. In 4:3 operation every line advances the scanner by one row. In quasi-16:9 operation the picture is compressed vertically by leaving out a fixed share of the video lines. The rows above and below the picture are filled with black by fast scanning, and during that time a black-signal flag is raised for the video path.

Each line is announced by a one-cycle line strobe. The first line of a field also carries a one-cycle field strobe. The block classifies the line at the edge on which the line strobe is taken. It then issues its vertical advance strobes from the next cycle, and holds the level outputs (black flag, horizontal-start enable, enable/clear permits) steady until the next line strobe. The pulse shapes sent to the panel are built downstream.

Top module: `wv_scan_ctrl`

## Requirements
- R1: After reset and before the first line strobe: `vck_stb` is low, `frp` is 0, `sblk` is 0, and `hst_en`, `en_ok` and `clr_ok` are 1.
- R2: With `wide_en` low, every line gives exactly one `vck_stb` pulse, in the cycle after the line strobe. For that line `hst_en`, `en_ok` and `clr_ok` are 1 and `sblk` is 0.
- R3: With `inv_field` low, outside a black band, `frp` inverts on every line. It is unchanged in the cycle after the line strobe (the cycle of the first `vck_stb`) and shows its new value one cycle later.
- R4: With `inv_field` high, outside a black band, `frp` inverts only on a line that carries the field strobe. It uses the same two-cycle timing as R3.
- R5: With `wide_en` high, the first 28 lines after the field strobe form the top black band. Band line 0, 2, 4… is a normal line: one strobe at offset 1 and `hst_en`=1. Band line 1, 3, 5… is a fast line: four strobes at offsets 1, 1+L/4, 1+2L/4 and 1+3L/4 (L = `LINE_CLKS`) and `hst_en`=0. On all band lines `sblk`=1 and `en_ok`=`clr_ok`=0.
- R6: In a black band, `frp` inverts only on even band lines (a four-line period), whatever `inv_field` says.
- R7: In the wide picture area with `pal_sel` low, picture line k (counted from 0 after the top band) is dropped when k mod 4 = 3. A dropped line has no strobe, `hst_en`=0, `sblk`=0 and `en_ok`=`clr_ok`=1. Every other picture line is a normal line.
- R8: In the wide picture area with `pal_sel` high, picture line k is dropped when k mod 8 is 1, 3 or 7: every second line is left out in the first half of each eight-line group and one in four in the second half.
- R9: The wide picture area ends with the normal line that brings the kept count to 163 (`panel_big`=0) or 169 (`panel_big`=1). A bottom band follows: 27 lines (small panel) or 28 lines (large panel), built as in R5 and R6. After that, every line until the next field strobe is idle: no strobe, `hst_en`=0, `sblk`=0 and `en_ok`=`clr_ok`=1.
- R10: A field strobe restarts the sequence at band line 0 from any point, including the middle of the picture area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_stb | input | 1 | One-cycle strobe at the start of each line, at least `LINE_CLKS` cycles apart |
| field_stb | input | 1 | High together with `line_stb` on the first line of a field |
| wide_en | input | 1 | 1 = quasi-16:9 compression with black bands |
| pal_sel | input | 1 | 1 = 625-line elimination pattern, 0 = 525-line pattern |
| panel_big | input | 1 | 1 = larger panel (169-row picture, 28-line bottom band) |
| inv_field | input | 1 | 1 = field polarity inversion, 0 = line polarity inversion |
| vck_stb | output | 1 | One-cycle strobe: advance the vertical scanner by one row |
| frp | output | 1 | AC drive polarity level |
| sblk | output | 1 | Black-signal flag, high on band lines |
| hst_en | output | 1 | Permit for the horizontal start pulse on this line |
| en_ok | output | 1 | Permit for the row enable pulse on this line |
| clr_ok | output | 1 | Permit for the clear pulse on this line |

## Verification
The bench targets the seams between regions. These are the last top-band line against the first picture line, the picture line that completes the kept count, and the hand-off from the bottom band to idle lines. A counter off by one there would show as a wrong strobe count or a misplaced `sblk` on one line. The two drop patterns are both run over a whole field, so a wrong modulus or a swapped pattern leaves the kept count and band position wrong. Every fast line's strobe positions are checked as a mask; a wrong quarter spacing moves a strobe off its offset. The polarity is checked one cycle before and one cycle after its expected change, across line inversion, field inversion and band override, and a field strobe is issued mid-picture to catch a design that only restarts from idle.

// File: rtl/wv_pkg.sv
package wv_pkg;

  localparam int unsigned CNT_W = 9;

  typedef enum logic [2:0] {
    K_NORM  = 3'd0,
    K_DROP  = 3'd1,
    K_BNORM = 3'd2,
    K_BQUAD = 3'd3,
    K_REST  = 3'd4
  } line_kind_e;

  typedef enum logic [1:0] {
    S_TOP  = 2'd0,
    S_DISP = 2'd1,
    S_BOT  = 2'd2,
    S_REST = 2'd3
  } sect_e;

  // Picture line elimination: 525-line drops one in four, 625-line drops
  // three of each eight (half of the first four, a quarter of the next four).
  function automatic logic drop_line(input logic [2:0] k3, input logic pal);
    if (pal) return (k3 == 3'd1) || (k3 == 3'd3) || (k3 == 3'd7);
    return (k3[1:0] == 2'd3);
  endfunction

  function automatic logic is_band(input line_kind_e k);
    return (k == K_BNORM) || (k == K_BQUAD);
  endfunction

  function automatic logic gives_row(input line_kind_e k);
    return (k == K_NORM) || (k == K_BNORM) || (k == K_BQUAD);
  endfunction

endpackage

// File: rtl/wv_line_seq.sv
module wv_line_seq
  import wv_pkg::*;
#(
  parameter int unsigned TOP_LINES  = 28,
  parameter int unsigned BOT_SMALL  = 27,
  parameter int unsigned BOT_BIG    = 28,
  parameter int unsigned DISP_SMALL = 163,
  parameter int unsigned DISP_BIG   = 169
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb,
  input  logic       field_stb,
  input  logic       wide_en,
  input  logic       pal_sel,
  input  logic       panel_big,
  input  logic       inv_field,
  output line_kind_e kind_q,
  output logic       tog_q
);

  localparam logic [CNT_W-1:0] TOP_N = CNT_W'(TOP_LINES);

  sect_e            sect_q, cur_sect, nx_sect;
  logic [CNT_W-1:0] cnt_q, cur_cnt, nx_cnt;
  logic [CNT_W-1:0] kept_q, cur_kept, nx_kept;
  logic [CNT_W-1:0] bot_n, disp_n;
  line_kind_e       kind_c;
  logic             tog_c;

  assign bot_n  = panel_big ? CNT_W'(BOT_BIG)  : CNT_W'(BOT_SMALL);
  assign disp_n = panel_big ? CNT_W'(DISP_BIG) : CNT_W'(DISP_SMALL);

  // Position of the line being announced now.
  always_comb begin
    if (field_stb) begin
      cur_sect = wide_en ? S_TOP : S_DISP;
      cur_cnt  = '0;
      cur_kept = '0;
    end else begin
      cur_sect = sect_q;
      cur_cnt  = cnt_q;
      cur_kept = kept_q;
    end
  end

  // Classification of the line.
  always_comb begin
    if (!wide_en) kind_c = K_NORM;
    else begin
      unique case (cur_sect)
        S_TOP, S_BOT: kind_c = cur_cnt[0] ? K_BQUAD : K_BNORM;
        S_DISP:       kind_c = drop_line(cur_cnt[2:0], pal_sel) ? K_DROP : K_NORM;
        default:      kind_c = K_REST;
      endcase
    end
  end

  // Polarity toggle decision for the line.
  always_comb begin
    if (is_band(kind_c)) tog_c = !cur_cnt[0];
    else if (inv_field)  tog_c = field_stb;
    else                 tog_c = 1'b1;
  end

  // Position of the following line.
  always_comb begin
    nx_sect = cur_sect;
    nx_cnt  = cur_cnt + 1'b1;
    nx_kept = cur_kept + CNT_W'(kind_c == K_NORM);
    unique case (cur_sect)
      S_TOP: if (nx_cnt == TOP_N) begin
        nx_sect = S_DISP;
        nx_cnt  = '0;
      end
      S_DISP: if (wide_en && kind_c == K_NORM && nx_kept == disp_n) begin
        nx_sect = S_BOT;
        nx_cnt  = '0;
      end
      S_BOT: if (nx_cnt == bot_n) begin
        nx_sect = S_REST;
        nx_cnt  = '0;
      end
      default: nx_cnt = cur_cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q <= S_DISP;
      cnt_q  <= '0;
      kept_q <= '0;
      kind_q <= K_NORM;
      tog_q  <= 1'b0;
    end else if (line_stb) begin
      sect_q <= nx_sect;
      cnt_q  <= nx_cnt;
      kept_q <= nx_kept;
      kind_q <= kind_c;
      tog_q  <= tog_c;
    end
  end

endmodule

// File: rtl/wv_strobe_gen.sv
module wv_strobe_gen
  import wv_pkg::*;
#(
  parameter int unsigned LINE_CLKS = 16,
  parameter int unsigned SPEEDUP   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_stb,
  input  line_kind_e kind,
  output logic       vck_stb,
  output logic       line_mark
);

  localparam int unsigned POS_W = $clog2(LINE_CLKS + 1);
  localparam int unsigned STEP  = LINE_CLKS / SPEEDUP;
  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(LINE_CLKS);

  logic [POS_W-1:0] pos_q;
  logic             quad_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pos_q <= POS_IDLE;
    else if (line_stb)         pos_q <= '0;
    else if (pos_q != POS_IDLE) pos_q <= pos_q + 1'b1;
  end

  assign line_mark = (pos_q == '0);

  always_comb begin
    quad_hit = 1'b0;
    for (int i = 1; i < int'(SPEEDUP); i++)
      if (pos_q == POS_W'(STEP * i)) quad_hit = 1'b1;
  end

  assign vck_stb = (line_mark && gives_row(kind)) || (kind == K_BQUAD && quad_hit);

endmodule

// File: rtl/wv_polarity.sv
module wv_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic line_mark,
  input  logic tog,
  output logic frp
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                frp <= 1'b0;
    else if (line_mark && tog) frp <= ~frp;
  end

endmodule

// File: rtl/wv_scan_ctrl.sv
module wv_scan_ctrl
  import wv_pkg::*;
#(
  parameter int unsigned LINE_CLKS  = 16,
  parameter int unsigned SPEEDUP    = 4,
  parameter int unsigned TOP_LINES  = 28,
  parameter int unsigned BOT_SMALL  = 27,
  parameter int unsigned BOT_BIG    = 28,
  parameter int unsigned DISP_SMALL = 163,
  parameter int unsigned DISP_BIG   = 169
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic field_stb,
  input  logic wide_en,
  input  logic pal_sel,
  input  logic panel_big,
  input  logic inv_field,
  output logic vck_stb,
  output logic frp,
  output logic sblk,
  output logic hst_en,
  output logic en_ok,
  output logic clr_ok
);

  line_kind_e kind_q;
  logic       tog_q;
  logic       line_mark;

  wv_line_seq #(
    .TOP_LINES (TOP_LINES),
    .BOT_SMALL (BOT_SMALL),
    .BOT_BIG   (BOT_BIG),
    .DISP_SMALL(DISP_SMALL),
    .DISP_BIG  (DISP_BIG)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .field_stb(field_stb),
    .wide_en  (wide_en),
    .pal_sel  (pal_sel),
    .panel_big(panel_big),
    .inv_field(inv_field),
    .kind_q   (kind_q),
    .tog_q    (tog_q)
  );

  wv_strobe_gen #(
    .LINE_CLKS(LINE_CLKS),
    .SPEEDUP  (SPEEDUP)
  ) u_stb (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_stb (line_stb),
    .kind     (kind_q),
    .vck_stb  (vck_stb),
    .line_mark(line_mark)
  );

  wv_polarity u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_mark(line_mark),
    .tog      (tog_q),
    .frp      (frp)
  );

  assign sblk   = is_band(kind_q);
  assign hst_en = (kind_q == K_NORM) || (kind_q == K_BNORM);
  assign en_ok  = !is_band(kind_q);
  assign clr_ok = !is_band(kind_q);

endmodule

// File: rtl/wv_scan_chk.sv
module wv_scan_chk
  import wv_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       line_stb,
  input logic       field_stb,
  input logic       wide_en,
  input logic       inv_field,
  input logic       vck_stb,
  input logic       frp,
  input logic       sblk,
  input logic       en_ok,
  input logic       clr_ok,
  input logic       line_mark,
  input line_kind_e kind_q
);

  AST_WIDE_OFF_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !wide_en) |=> (!sblk && en_ok && clr_ok)); // R2

  AST_FRP_AFTER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (frp != $past(frp)) |-> $past(line_mark)); // R3

  AST_FIELD_INV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stb && !field_stb && inv_field && !wide_en) |=> ##1 $stable(frp)); // R4

  AST_EXTRA_STB_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (vck_stb && !line_mark) |-> sblk); // R5

  AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    vck_stb |=> !vck_stb); // R5

  AST_SILENT_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == K_DROP || kind_q == K_REST) |-> (!vck_stb && en_ok)); // R7

endmodule

bind wv_scan_ctrl wv_scan_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_stb (line_stb),
  .field_stb(field_stb),
  .wide_en  (wide_en),
  .inv_field(inv_field),
  .vck_stb  (vck_stb),
  .frp      (frp),
  .sblk     (sblk),
  .en_ok    (en_ok),
  .clr_ok   (clr_ok),
  .line_mark(line_mark),
  .kind_q   (kind_q)
);

// File: tb/test_wv_scan_ctrl.sv
`timescale 1ns/1ps
module test_wv_scan_ctrl;

  localparam int LC = 16;
  localparam int QS = LC / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0, field_stb = 1'b0;
  logic wide_en = 1'b0, pal_sel = 1'b0, panel_big = 1'b0, inv_field = 1'b0;
  logic vck_stb, frp, sblk, hst_en, en_ok, clr_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wv_scan_ctrl #(.LINE_CLKS(LC)) i_wv_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
    .wide_en(wide_en), .pal_sel(pal_sel), .panel_big(panel_big), .inv_field(inv_field),
    .vck_stb(vck_stb), .frp(frp), .sblk(sblk), .hst_en(hst_en),
    .en_ok(en_ok), .clr_ok(clr_ok)
  );

  typedef struct {
    logic [LC-1:0] mask;
    bit sblk, hst, en, frp_old, frp_new;
    string req, preq;
  } item_t;

  item_t sb[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model state: 0 top band, 1 picture, 2 bottom band, 3 idle
  int  m_sect = 1, m_cnt = 0, m_kept = 0;
  bit  m_frp = 1'b0;

  task automatic send_line(input bit fs);
    item_t it;
    bit band, quad, drop, idle, tog;
    int disp_n, bot_n;
    disp_n = panel_big ? 169 : 163;
    bot_n  = panel_big ? 28 : 27;
    if (fs) begin m_sect = wide_en ? 0 : 1; m_cnt = 0; m_kept = 0; end
    band = 0; quad = 0; drop = 0; idle = 0;
    if (wide_en) begin
      if (m_sect == 0 || m_sect == 2) begin band = 1; quad = (m_cnt % 2) == 1; end
      else if (m_sect == 3) idle = 1;
      else if (pal_sel) drop = (m_cnt % 8 == 1) || (m_cnt % 8 == 3) || (m_cnt % 8 == 7);
      else drop = (m_cnt % 4 == 3);
    end
    it.mask = '0;
    if (!drop && !idle) it.mask[1] = 1'b1;
    if (quad) begin it.mask[1+QS] = 1'b1; it.mask[1+2*QS] = 1'b1; it.mask[1+3*QS] = 1'b1; end
    it.sblk = band;
    it.hst  = !(drop || idle || quad);
    it.en   = !band;
    if (band) tog = (m_cnt % 2) == 0;
    else tog = inv_field ? fs : 1'b1;
    it.frp_old = m_frp;
    if (tog) m_frp = !m_frp;
    it.frp_new = m_frp;
    if (!wide_en) it.req = "R2";
    else if (fs && m_sect != 3 && m_cnt != 0) it.req = "R10";
    else if (m_sect == 0) it.req = "R5";
    else if (m_sect == 1) it.req = pal_sel ? "R8" : "R7";
    else it.req = "R9";
    if (band) it.preq = "R6";
    else it.preq = inv_field ? "R4" : "R3";
    // advance the model
    m_cnt++;
    if (wide_en) begin
      if (m_sect == 0 && m_cnt == 28) begin m_sect = 1; m_cnt = 0; end
      else if (m_sect == 1 && !drop) begin
        m_kept++;
        if (m_kept == disp_n) begin m_sect = 2; m_cnt = 0; end
      end
      else if (m_sect == 2 && m_cnt == bot_n) begin m_sect = 3; m_cnt = 0; end
    end
    sb.push_back(it);
    @(posedge clk); #1;
    line_stb = 1'b1; field_stb = fs;
    @(posedge clk); #1;
    line_stb = 1'b0; field_stb = 1'b0;
    repeat (LC - 2) @(posedge clk);
  endtask

  task automatic send_field(input int n);
    for (int i = 0; i < n; i++) send_line(i == 0);
  endtask

  // monitor: pops an expected line at each line strobe and compares it
  initial begin
    item_t cur;
    int off;
    logic [LC-1:0] seen;
    bit active;
    active = 0; off = 0; seen = '0;
    forever begin
      @(negedge clk);
      if (rst_n && line_stb) begin
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R2 scoreboard: actual 0 expected 1 queued line");
        end else cur = sb.pop_front();
        active = 1; off = 0; seen = '0;
      end else if (active) begin
        off++;
        if (vck_stb) seen[off] = 1'b1;
        if (off == 1) chk(cur.preq, "frp before change", int'(frp), int'(cur.frp_old));
        if (off == 2) begin
          chk(cur.preq, "frp after change", int'(frp), int'(cur.frp_new));
          chk(cur.req, "sblk", int'(sblk), int'(cur.sblk));
          chk(cur.req, "hst_en", int'(hst_en), int'(cur.hst));
          chk(cur.req, "en_ok", int'(en_ok), int'(cur.en));
          chk(cur.req, "clr_ok", int'(clr_ok), int'(cur.en));
        end
        if (off == LC - 1) begin
          chk(cur.req, "strobe mask", int'(seen), int'(cur.mask));
          active = 0;
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "vck_stb", int'(vck_stb), 0);
    chk("R1", "frp", int'(frp), 0);
    chk("R1", "sblk", int'(sblk), 0);
    chk("R1", "hst_en", int'(hst_en), 1);
    chk("R1", "en_ok", int'(en_ok), 1);
    chk("R1", "clr_ok", int'(clr_ok), 1);
    @(posedge clk);
    // R2 / R3: plain 4:3 with line inversion
    send_field(40);
    // R4: field inversion
    inv_field = 1'b1;
    send_field(20);
    send_field(20);
    // R5 R6 R7 R9: wide, 525-line pattern, small panel
    inv_field = 1'b0; wide_en = 1'b1;
    send_field(300);
    // R10: restart in the middle of the picture area
    send_field(60);
    send_field(10);
    // R8 R9 R6: wide, 625-line pattern, large panel, field inversion
    pal_sel = 1'b1; panel_big = 1'b1; inv_field = 1'b1;
    send_field(340);
    // back to 4:3
    wide_en = 1'b0; pal_sel = 1'b0; panel_big = 1'b0; inv_field = 1'b0;
    send_field(10);
    repeat (LC + 4) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule